// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state. After a start pulse it waits out a stabilisation interval, then emits a fixed stream of commands (one precharge, a run of auto-refresh commands and a mode-register load), each followed by an idle slot. The whole pass, including the wait, is performed twice before the block reports completion. While a pass is running, automatic refresh in the surrounding controller is held off. At the end of each pass the normal refresh setting comes back.

The mode-register value is captured when the sequence is accepted. It is either taken directly from a nonzero preset input, or derived from the CAS-latency code, the clock-speed select and the bus-width select. The meaning of the latency code depends on the speed select. The derived value comes from a base of 0x40: bit 5 is set for a latency of three, and the value is shifted right by one for a 16-bit bus.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and after it, the block is idle: `cmd_vld_o` low, `cmd_o` = 0, `done_o` low, `ref_inhibit_o` high, `mrs_data_o` = 0x00.
- R2: The first command of each pass is issued exactly WAIT_CYCLES = CLK_MHZ*WAIT_US clock cycles after the pass begins. Pass one begins at the clock edge that samples `start_i`.
- R3: Each pass issues 2*(REFRESH_COUNT+2) command slots in this order: precharge, then REFRESH_COUNT refreshes, then mode-register set. Every command is followed by a NOP slot, including the last. The codes are NOP=0, MRS=1, REFRESH=2, PRECHARGE=3.
- R4: Successive slots within a pass are issued exactly CMD_GAP (at least 5) cycles apart. `cmd_vld_o` is high for one cycle per slot, NOP slots included. `cmd_o` reads 0 whenever `cmd_vld_o` is low.
- R5: When the preset is zero, mode data is 0x40 for CAS 2 on 32-bit, 0x60 for CAS 3 on 32-bit, 0x20 for CAS 2 on 16-bit and 0x30 for CAS 3 on 16-bit. With `speed100_i`=1, code 0 means CAS 2. With `speed100_i`=0, code 1 means CAS 2. Every other code means CAS 3.
- R6: A nonzero `mrs_preset_i` is passed to `mrs_data_o` unchanged, and no derivation is applied.
- R7: `ref_inhibit_o` stays high throughout each pass. It drops CMD_GAP cycles after the last slot of a pass. Between passes it is low for exactly one cycle, and it is high again as the next wait begins. It stays low once the block is done.
- R8: `done_o` rises together with the final refresh restore, after PASSES complete passes. It stays high until reset.
- R9: A start pulse has no effect while a sequence is running, between passes, or after done.
- R10: `mrs_data_o` is captured on the cycle after start is accepted. It holds that value even if the configuration inputs change later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin the power-up sequence (accepted when idle) |
| cas_code_i | input | 2 | CAS-latency code, read according to speed select |
| speed100_i | input | 1 | 1 = 100 MHz interpretation, 0 = 50 MHz |
| bus32_i | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| mrs_preset_i | input | 8 | Precomputed mode data; zero selects derivation |
| cmd_o | output | 2 | Command code (0 NOP, 1 MRS, 2 REFRESH, 3 PRECHARGE) |
| cmd_vld_o | output | 1 | One-cycle strobe per issued slot |
| mrs_data_o | output | 8 | Mode-register data word |
| ref_inhibit_o | output | 1 | High keeps automatic refresh disabled |
| done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
Every output is registered. Counting the edge that samples start as cycle 0, the mode word appears at cycle 0. Slot k of pass one appears at cycle WAIT_CYCLES + k*CMD_GAP. The refresh restore comes at WAIT_CYCLES + SLOTS*CMD_GAP, and pass two starts one cycle later, so every pass-two time is that cycle plus its pass-one offset. The bench samples 1 ns after each rising edge. It holds a cycle index taken from the start edge, computes from that index alone which slot, inhibit level and done level are due, and compares all four outputs on every cycle of the run. Ignored start pulses and mid-run configuration changes are injected at chosen cycle indices. The comparison continues unchanged through them, so any disturbance would show up in the same schedule.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_MRS = 2'd1,
    CMD_REF = 2'd2,
    CMD_PRE = 2'd3
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STREAM,
    ST_REST,
    ST_DONE
  } seq_state_e;

  localparam logic [7:0] MODE_BASE     = 8'h40;
  localparam logic [7:0] MODE_CAS3_SET = 8'h20;

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pwrup_mode_calc.sv
module pwrup_mode_calc
  import sdram_init_pkg::*;
(
  input  logic [1:0] cas_code_i,
  input  logic       speed100_i,
  input  logic       bus32_i,
  input  logic [7:0] preset_i,
  output logic [7:0] mode_o
);
  logic       cas3;
  logic [7:0] wide_val;
  logic [7:0] derived;

  always_comb begin
    // latency code meaning shifts with the clock-speed select
    if (speed100_i) cas3 = (cas_code_i != 2'd0);
    else            cas3 = (cas_code_i != 2'd1);
    wide_val = MODE_BASE | (cas3 ? MODE_CAS3_SET : 8'h00);
    derived  = bus32_i ? wide_val : (wide_val >> 1);
    mode_o   = (preset_i != 8'h00) ? preset_i : derived;
  end
endmodule

// File: rtl/pwrup_cmd_table.sv
module pwrup_cmd_table
  import sdram_init_pkg::*;
#(
  parameter int REFRESH_COUNT = 8,
  localparam int SLOTS = 2 * (REFRESH_COUNT + 2),
  localparam int IDXW  = $clog2(SLOTS)
) (
  input  logic [IDXW-1:0] idx_i,
  output sdram_cmd_e      code_o
);
  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(SLOTS - 1);

  sdram_cmd_e table_w [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g % 2 == 1) begin : g_nop
      assign table_w[g] = CMD_NOP;
    end else if (g == 0) begin : g_pre
      assign table_w[g] = CMD_PRE;
    end else if (g == SLOTS - 2) begin : g_mrs
      assign table_w[g] = CMD_MRS;
    end else begin : g_ref
      assign table_w[g] = CMD_REF;
    end
  end

  assign code_o = (idx_i <= IDX_LAST) ? table_w[idx_i] : CMD_NOP;
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ       = 125,
  parameter int WAIT_US       = 200,
  parameter int CMD_GAP       = 5,
  parameter int REFRESH_COUNT = 8,
  parameter int PASSES        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] cas_code_i,
  input  logic       speed100_i,
  input  logic       bus32_i,
  input  logic [7:0] mrs_preset_i,
  output logic [1:0] cmd_o,
  output logic       cmd_vld_o,
  output logic [7:0] mrs_data_o,
  output logic       ref_inhibit_o,
  output logic       done_o
);
  localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;
  localparam int WCW   = $clog2(WAIT_CYCLES + 1);
  localparam int GCW   = $clog2(CMD_GAP + 1);
  localparam int SLOTS = 2 * (REFRESH_COUNT + 2);
  localparam int IDXW  = $clog2(SLOTS);
  localparam int PCW   = $clog2(PASSES + 1);
  localparam logic [WCW-1:0]  WAIT_LAST = WCW'(WAIT_CYCLES - 1);
  localparam logic [GCW-1:0]  GAP_LAST  = GCW'(CMD_GAP - 1);
  localparam logic [IDXW-1:0] SLOT_LAST = IDXW'(SLOTS - 1);
  localparam logic [PCW-1:0]  PASS_LAST = PCW'(PASSES - 1);

  logic srst_n;

  seq_state_e     state_q, state_d;
  logic [WCW-1:0]  wait_q, wait_d;
  logic [GCW-1:0]  gap_q, gap_d;
  logic [IDXW-1:0] slot_q, slot_d;
  logic [PCW-1:0]  pass_q, pass_d;
  sdram_cmd_e     cmd_q, cmd_d;
  logic           vld_q, vld_d;
  logic           inh_q, inh_d;
  logic           done_q, done_d;
  logic [7:0]     mode_q;
  logic           mode_en;

  logic [IDXW-1:0] tbl_idx;
  sdram_cmd_e     tbl_code;
  logic [7:0]     mode_calc;

  pwrup_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (srst_n)
  );

  pwrup_mode_calc u_mode (
    .cas_code_i (cas_code_i),
    .speed100_i (speed100_i),
    .bus32_i    (bus32_i),
    .preset_i   (mrs_preset_i),
    .mode_o     (mode_calc)
  );

  pwrup_cmd_table #(.REFRESH_COUNT(REFRESH_COUNT)) u_tbl (
    .idx_i  (tbl_idx),
    .code_o (tbl_code)
  );

  // slot 0 is fetched leaving the wait, later slots one ahead of slot_q
  assign tbl_idx = (state_q == ST_STREAM) ? (slot_q + IDXW'(1)) : '0;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    gap_d   = gap_q;
    slot_d  = slot_q;
    pass_d  = pass_q;
    cmd_d   = CMD_NOP;
    vld_d   = 1'b0;
    inh_d   = inh_q;
    done_d  = done_q;
    mode_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_WAIT;
          wait_d  = '0;
          pass_d  = '0;
          inh_d   = 1'b1;
          mode_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (wait_q == WAIT_LAST) begin
          state_d = ST_STREAM;
          slot_d  = '0;
          gap_d   = '0;
          cmd_d   = tbl_code;
          vld_d   = 1'b1;
        end else begin
          wait_d = wait_q + WCW'(1);
        end
      end
      ST_STREAM: begin
        if (gap_q == GAP_LAST) begin
          gap_d = '0;
          if (slot_q == SLOT_LAST) begin
            inh_d = 1'b0;
            if (pass_q == PASS_LAST) begin
              state_d = ST_DONE;
              done_d  = 1'b1;
            end else begin
              state_d = ST_REST;
              pass_d  = pass_q + PCW'(1);
            end
          end else begin
            slot_d = slot_q + IDXW'(1);
            cmd_d  = tbl_code;
            vld_d  = 1'b1;
          end
        end else begin
          gap_d = gap_q + GCW'(1);
        end
      end
      ST_REST: begin
        inh_d   = 1'b1;
        wait_d  = '0;
        state_d = ST_WAIT;
      end
      ST_DONE: begin
        state_d = ST_DONE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      gap_q   <= '0;
      slot_q  <= '0;
      pass_q  <= '0;
      cmd_q   <= CMD_NOP;
      vld_q   <= 1'b0;
      inh_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      gap_q   <= gap_d;
      slot_q  <= slot_d;
      pass_q  <= pass_d;
      cmd_q   <= cmd_d;
      vld_q   <= vld_d;
      inh_q   <= inh_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mode_q <= 8'h00;
    else if (mode_en) mode_q <= mode_calc;
  end

  assign cmd_o         = cmd_q;
  assign cmd_vld_o     = vld_q;
  assign mrs_data_o    = mode_q;
  assign ref_inhibit_o = inh_q;
  assign done_o        = done_q;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int CMD_GAP = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_o,
  input logic       cmd_vld_o,
  input logic [7:0] mrs_data_o,
  input logic       ref_inhibit_o,
  input logic       done_o
);
  logic [15:0] since_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (cmd_vld_o) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != 16'hFFFF) begin
      since_q <= since_q + 16'd1;
    end
  end

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |=> !cmd_vld_o);

  a_r4_nop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld_o |-> (cmd_o == 2'd0));

  a_r4_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && seen_q) |-> (since_q >= 16'(CMD_GAP - 1)));

  a_r7_cmd_while_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> ref_inhibit_o);

  a_r7_refresh_back_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ref_inhibit_o);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  a_r10_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> $stable(mrs_data_o));
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(.CMD_GAP(CMD_GAP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_o         (cmd_o),
  .cmd_vld_o     (cmd_vld_o),
  .mrs_data_o    (mrs_data_o),
  .ref_inhibit_o (ref_inhibit_o),
  .done_o        (done_o)
);

// File: tb/sim_sdram_pwrup_seq.sv
module sim_sdram_pwrup_seq;
  localparam int CLK_MHZ  = 125;
  localparam int WAIT_US  = 1;
  localparam int GAP      = 5;
  localparam int REFS     = 8;
  localparam int W        = CLK_MHZ * WAIT_US;
  localparam int SLOTS    = 2 * (REFS + 2);
  localparam int PASS_LEN = W + SLOTS * GAP + 1;
  localparam int DONE_N   = 2 * W + 2 * SLOTS * GAP + 1;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [1:0] cas_code_i;
  logic       speed100_i;
  logic       bus32_i;
  logic [7:0] mrs_preset_i;
  logic [1:0] cmd_o;
  logic       cmd_vld_o;
  logic [7:0] mrs_data_o;
  logic       ref_inhibit_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  sdram_pwrup_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .CMD_GAP(GAP),
    .REFRESH_COUNT(REFS), .PASSES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cas_code_i(cas_code_i),
    .speed100_i(speed100_i), .bus32_i(bus32_i), .mrs_preset_i(mrs_preset_i),
    .cmd_o(cmd_o), .cmd_vld_o(cmd_vld_o), .mrs_data_o(mrs_data_o),
    .ref_inhibit_o(ref_inhibit_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not finish (act=running exp=finished)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_mode(input bit spd100, input int code,
                                  input bit b32, input int preset);
    bit c3;
    if (preset != 0) return preset;
    c3 = spd100 ? (code != 0) : (code != 1);
    if (b32) return c3 ? 'h60 : 'h40;
    return c3 ? 'h30 : 'h20;
  endfunction

  function automatic int slot_code(input int k);
    if (k % 2 == 1) return 0;
    if (k == 0) return 3;
    if (k == SLOTS - 2) return 1;
    return 2;
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    tick();
    tick();
  endtask

  task automatic set_cfg(input bit spd, input int code, input bit b32, input int preset);
    speed100_i   = spd;
    cas_code_i   = code[1:0];
    bus32_i      = b32;
    mrs_preset_i = preset[7:0];
  endtask

  // R1: outputs while held in reset and right after release
  task automatic t_reset_state();
    rst_n = 1'b0;
    tick();
    check(cmd_vld_o == 1'b0, "R1", "vld in reset", cmd_vld_o, 0);
    check(cmd_o == 2'd0, "R1", "cmd in reset", cmd_o, 0);
    check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    check(ref_inhibit_o == 1'b1, "R1", "inhibit in reset", ref_inhibit_o, 1);
    check(mrs_data_o == 8'h00, "R1", "mode in reset", mrs_data_o, 0);
    rst_n = 1'b1;
    tick();
    tick();
    tick();
    check(!done_o && ref_inhibit_o && !cmd_vld_o, "R1", "idle after release",
          {done_o, ref_inhibit_o, cmd_vld_o}, 3'b010);
  endtask

  // R5 / R6: mode word captured one edge after start
  task automatic t_mode(input bit spd, input int code, input bit b32,
                        input int preset, input string req);
    int e;
    apply_reset();
    set_cfg(spd, code, b32, preset);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    e = exp_mode(spd, code, b32, preset);
    check(int'(mrs_data_o) == e, req, "mode word", mrs_data_o, e);
  endtask

  // Full two-pass run compared cycle by cycle against the schedule.
  task automatic t_full_run(input bit spd, input int code, input bit b32,
                            input int preset, input int start_at_a,
                            input int start_at_b, input int cfg_at,
                            input string name);
    int em, bad_cmd, bad_vld, bad_inh, bad_done, bad_mode, first_vld;
    int a_cmd, e_cmd, a_inh, e_inh;
    apply_reset();
    set_cfg(spd, code, b32, preset);
    em = exp_mode(spd, code, b32, preset);
    bad_cmd = 0; bad_vld = 0; bad_inh = 0; bad_done = 0; bad_mode = 0;
    first_vld = -1;
    a_cmd = 0; e_cmd = 0; a_inh = 0; e_inh = 0;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int n = 0; n <= DONE_N + 60; n++) begin
      int off, rel, k;
      bit ev, ei, ed;
      int ec;
      off = (n >= PASS_LEN) ? n - PASS_LEN : n;
      rel = off - W;
      ev = 1'b0; ec = 0; ei = 1'b1; ed = 1'b0;
      if (n >= DONE_N) begin
        ei = 1'b0; ed = 1'b1;
      end else begin
        if (rel >= 0 && rel % GAP == 0 && rel / GAP < SLOTS) begin
          k = rel / GAP;
          ev = 1'b1;
          ec = slot_code(k);
        end
        if (n == PASS_LEN - 1) ei = 1'b0;
      end
      if (cmd_vld_o && first_vld < 0) first_vld = n;
      if (cmd_vld_o != ev) bad_vld++;
      if (int'(cmd_o) != ec) begin
        if (bad_cmd == 0) begin a_cmd = cmd_o; e_cmd = ec; end
        bad_cmd++;
      end
      if (ref_inhibit_o != ei) begin
        if (bad_inh == 0) begin a_inh = n; e_inh = ei; end
        bad_inh++;
      end
      if (done_o != ed) bad_done++;
      if (int'(mrs_data_o) != em) bad_mode++;
      start_i = (n == start_at_a || n == start_at_b);
      if (n == cfg_at) set_cfg(!spd, code + 1, !b32, preset);
      tick();
    end
    start_i = 1'b0;
    $display("run %s complete", name);
    check(first_vld == W, "R2", "first command cycle", first_vld, W);
    check(bad_cmd == 0, "R3", "command codes", a_cmd, e_cmd);
    check(bad_vld == 0, "R4", "strobe schedule mismatches", bad_vld, 0);
    check(bad_inh == 0, "R7", "inhibit level (first bad cycle/exp)", a_inh, e_inh);
    check(bad_done == 0, "R8", "done level mismatches", bad_done, 0);
    check(bad_mode == 0, "R10", "mode word held", bad_mode, 0);
    if (start_at_a >= 0 || start_at_b >= 0)
      check(bad_vld == 0 && bad_done == 0, "R9", "extra start ignored",
            bad_vld + bad_done, 0);
  endtask

  // R1: asynchronous reset in the middle of a pass
  task automatic t_mid_reset();
    apply_reset();
    set_cfg(1'b1, 0, 1'b1, 0);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int i = 0; i < W + 3 * GAP; i++) tick();
    rst_n = 1'b0;
    #1;
    check(cmd_vld_o == 1'b0 && cmd_o == 2'd0, "R1", "cmd after mid reset",
          {cmd_vld_o, cmd_o}, 0);
    check(ref_inhibit_o == 1'b1, "R1", "inhibit after mid reset", ref_inhibit_o, 1);
    check(mrs_data_o == 8'h00 && !done_o, "R1", "mode/done after mid reset",
          mrs_data_o, 0);
    tick();
    rst_n = 1'b1;
    tick();
    tick();
    tick();
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    set_cfg(1'b1, 0, 1'b1, 0);
    t_reset_state();
    t_mode(1'b1, 0, 1'b1, 0, "R5");
    t_mode(1'b1, 1, 1'b1, 0, "R5");
    t_mode(1'b1, 3, 1'b0, 0, "R5");
    t_mode(1'b0, 1, 1'b1, 0, "R5");
    t_mode(1'b0, 0, 1'b1, 0, "R5");
    t_mode(1'b0, 2, 1'b0, 0, "R5");
    t_mode(1'b0, 1, 1'b0, 0, "R5");
    t_mode(1'b1, 2, 1'b0, 'h5A, "R6");
    t_mode(1'b0, 1, 1'b1, 'h01, "R6");
    t_full_run(1'b1, 0, 1'b1, 0, -1, -1, -1, "plain");
    t_full_run(1'b0, 2, 1'b0, 0, 60, DONE_N + 10, 100, "busy_start_cfg_change");
    t_full_run(1'b1, 1, 1'b1, 'hA3, PASS_LEN - 1, W + 7 * GAP, W + 2, "between_passes");
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule